// File: doc/BRIEF.md
# Polled Parallel Port Bridge

This block gives a processor a small set of byte-wide registers in its data address space. Through them the processor drives an input/output byte channel and four parallel pin groups whose direction it chooses. There are no separate I/O cycles. Software issues ordinary read and write strobes with an address. It learns when to move data by polling flag bits. The flags are set and cleared by the data accesses and by the device-side strobes, never by software writing them.

On the device side, an arriving byte is offered with a one-cycle valid strobe. The outgoing byte sits on a data bus together with a valid flag until the device pulses accept. The pin groups are two full-width ports (A, B) and one port C that is split into two half-width nibbles. Each of the four groups drives its latched value only while it is configured as an output.

Top module: `polled_port_bridge`

## Requirements
- R1: Address map: 0 data, 1 status, 2 command, 4 port A, 5 port B, 6 port C. `bus_rdata` is registered and shows the read value in the cycle after a `bus_rd` strobe. It is zero in the cycle after any cycle without `bus_rd`. Unmapped addresses read zero, and writes to them change nothing.
- R2: The command register can only be written. A read at address 2 returns zero whatever was stored.
- R3: The status register can only be read, and writes to address 1 change no state. Its layout is bit 0 input ready, bit 1 output full, bit 2 overrun, and all higher bits zero.
- R4: Input ready is set on the edge where `dev_in_valid` is high. It clears on a data-register read unless a new byte arrives on that same edge, in which case it stays set.
- R5: Output full is set by a data-register write and cleared by `dev_out_accept`. A write on the same edge as an accept leaves it set. `dev_out_valid` shows this flag.
- R6: A data-register read returns the last byte delivered on `dev_in_data`. A data-register write loads the output buffer, which appears on `dev_out_data`.
- R7: Overrun is set when a byte arrives while input ready is set and no data read is consuming it. It is cleared by a status read, and a new overrun on that same edge wins.
- R8: Command bits 0..3 set the direction of A, B, C-low and C-high (1 = input, 0 = output). The `*_oe` outputs are the inverse of these bits. A group configured as input drives zeros on its output pins.
- R9: A port read returns the input pins for groups configured as input and the latched value for groups configured as output. Writes to a port address update its latch in either direction. Port C takes bits 3:0 for C-low and bits 7:4 for C-high.
- R10: After synchronous reset, all flags and buffers are zero, every group is an input (command 0x0F), all pin outputs are zero and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_in_valid | input | 1 | New input byte strobe |
| dev_in_data | input | 8 | Input byte |
| dev_out_valid | output | 1 | Output buffer full |
| dev_out_data | output | 8 | Output buffer |
| dev_out_accept | input | 1 | Device takes the output byte |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A pins out |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B pins out |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pins in (high nibble C-high) |
| pc_out | output | 8 | Port C pins out |
| pc_oe | output | 2 | Port C drive enables {C-high, C-low} |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. Under that rule a port write and a command write can never share an edge, so a group's direction is stable across its own latch update. `dev_out_accept` and `dev_in_valid` may arrive at any time, including together with the bus accesses that race them. The stimulus picks one bus operation per cycle, so the strobes stay exclusive. The device strobes are drawn freely, and directed cases line them up against data reads, status reads and data writes.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADR_DATA = 3'd0;
  localparam logic [AW-1:0] ADR_STAT = 3'd1;
  localparam logic [AW-1:0] ADR_CMD  = 3'd2;
  localparam logic [AW-1:0] ADR_PA   = 3'd4;
  localparam logic [AW-1:0] ADR_PB   = 3'd5;
  localparam logic [AW-1:0] ADR_PC   = 3'd6;

  localparam int ST_RDY  = 0;
  localparam int ST_FULL = 1;
  localparam int ST_OVR  = 2;

  localparam int NGRP = 4;

  typedef struct packed {
    logic data_rd;
    logic data_wr;
    logic stat_rd;
    logic cmd_wr;
    logic pa_wr;
    logic pb_wr;
    logic pc_wr;
  } pbr_sel_t;
endpackage

// File: rtl/pbr_decode.sv
module pbr_decode
  import pbr_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  output pbr_sel_t      sel
);
  always_comb begin
    sel         = '0;
    sel.data_rd = rd && (addr == ADR_DATA);
    sel.data_wr = wr && (addr == ADR_DATA);
    sel.stat_rd = rd && (addr == ADR_STAT);
    sel.cmd_wr  = wr && (addr == ADR_CMD);
    sel.pa_wr   = wr && (addr == ADR_PA);
    sel.pb_wr   = wr && (addr == ADR_PB);
    sel.pc_wr   = wr && (addr == ADR_PC);
  end
endmodule

// File: rtl/pbr_flags.sv
module pbr_flags #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          data_rd,
  input  logic          data_wr,
  input  logic          stat_rd,
  input  logic [DW-1:0] wdata,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          out_accept,
  output logic [DW-1:0] in_buf,
  output logic [DW-1:0] out_buf,
  output logic          in_rdy,
  output logic          out_full,
  output logic          ovr
);
  logic collide;
  assign collide = in_valid && in_rdy && !data_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_buf   <= '0;
      out_buf  <= '0;
      in_rdy   <= 1'b0;
      out_full <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (in_valid) in_buf <= in_data;
      if (data_wr)  out_buf <= wdata;
      in_rdy   <= in_valid || (in_rdy && !data_rd);
      out_full <= data_wr || (out_full && !out_accept);
      ovr      <= collide || (ovr && !stat_rd);
    end
  end

  AST_RDY_SET:  assert property (@(posedge clk) disable iff (rst) in_valid |=> in_rdy);  // R4
  AST_RDY_CLR:  assert property (@(posedge clk) disable iff (rst) (data_rd && !in_valid) |=> !in_rdy);  // R4
  AST_FULL_SET: assert property (@(posedge clk) disable iff (rst) data_wr |=> out_full);  // R5
  AST_FULL_CLR: assert property (@(posedge clk) disable iff (rst) (out_accept && !data_wr) |=> !out_full);  // R5
  AST_OVR_SET:  assert property (@(posedge clk) disable iff (rst) (in_valid && in_rdy && !data_rd) |=> ovr);  // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) !data_wr |=> $stable(out_buf));  // R6
endmodule

// File: rtl/pbr_port_slice.sv
module pbr_port_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         dir_in,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic         pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst)        latch_q <= '0;
    else if (wr_en) latch_q <= wdata;
  end

  assign pin_oe  = !dir_in;
  assign pin_out = dir_in ? '0 : latch_q;
  assign rd_val  = dir_in ? pin_in : latch_q;

  AST_DRIVE_NEW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !dir_in) |=> (pin_out == $past(wdata)));  // R8
  AST_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
    dir_in |-> (pin_out == '0 && rd_val == pin_in));  // R9
endmodule

// File: rtl/polled_port_bridge.sv
module polled_port_bridge
  import pbr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_accept,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [1:0]    pc_oe
);
  localparam int HW     = DW / 2;
  localparam int FLAT_W = 3 * DW;
  localparam logic [DW-1:0] CMD_RST = DW'(4'hF);

  pbr_sel_t          sel;
  logic [DW-1:0]     cmd_q;
  logic [DW-1:0]     in_buf, out_buf;
  logic              in_rdy, out_full, ovr;
  logic [DW-1:0]     status;
  logic [FLAT_W-1:0] pin_in_flat, pin_out_flat, rd_flat;
  logic [NGRP-1:0]   grp_wr, grp_oe;

  pbr_decode u_dec (
    .addr (bus_addr),
    .rd   (bus_rd),
    .wr   (bus_wr),
    .sel  (sel)
  );

  pbr_flags #(.DW(DW)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .data_rd    (sel.data_rd),
    .data_wr    (sel.data_wr),
    .stat_rd    (sel.stat_rd),
    .wdata      (bus_wdata),
    .in_valid   (dev_in_valid),
    .in_data    (dev_in_data),
    .out_accept (dev_out_accept),
    .in_buf     (in_buf),
    .out_buf    (out_buf),
    .in_rdy     (in_rdy),
    .out_full   (out_full),
    .ovr        (ovr)
  );

  always_ff @(posedge clk) begin
    if (rst)             cmd_q <= CMD_RST;
    else if (sel.cmd_wr) cmd_q <= bus_wdata;
  end

  assign pin_in_flat = {pc_in, pb_in, pa_in};
  assign grp_wr      = {sel.pc_wr, sel.pc_wr, sel.pb_wr, sel.pa_wr};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int SW  = (g < 2) ? DW : HW;
    localparam int OFS = (g < 2) ? g * DW : 2 * DW + (g - 2) * HW;
    localparam int WOF = (g == 3) ? HW : 0;
    pbr_port_slice #(.W(SW)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (grp_wr[g]),
      .wdata   (bus_wdata[WOF +: SW]),
      .dir_in  (cmd_q[g]),
      .pin_in  (pin_in_flat[OFS +: SW]),
      .pin_out (pin_out_flat[OFS +: SW]),
      .pin_oe  (grp_oe[g]),
      .rd_val  (rd_flat[OFS +: SW])
    );
  end

  assign pa_out = pin_out_flat[DW-1:0];
  assign pb_out = pin_out_flat[2*DW-1:DW];
  assign pc_out = pin_out_flat[3*DW-1:2*DW];
  assign pa_oe  = grp_oe[0];
  assign pb_oe  = grp_oe[1];
  assign pc_oe  = grp_oe[3:2];

  always_comb begin
    status         = '0;
    status[ST_RDY]  = in_rdy;
    status[ST_FULL] = out_full;
    status[ST_OVR]  = ovr;
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADR_DATA: bus_rdata <= in_buf;
        ADR_STAT: bus_rdata <= status;
        ADR_PA:   bus_rdata <= rd_flat[DW-1:0];
        ADR_PB:   bus_rdata <= rd_flat[2*DW-1:DW];
        ADR_PC:   bus_rdata <= rd_flat[3*DW-1:2*DW];
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign dev_out_valid = out_full;
  assign dev_out_data  = out_buf;

  AST_CMD_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_CMD) |=> (bus_rdata == '0));  // R2
  AST_STAT_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADR_STAT) |=> (bus_rdata[DW-1:3] == '0));  // R3
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));  // R1
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));  // R1
endmodule

// File: tb/polled_port_bridge_bench.sv
module polled_port_bridge_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] bus_addr;
  logic       bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       dev_in_valid;
  logic [7:0] dev_in_data;
  logic       dev_out_valid;
  logic [7:0] dev_out_data;
  logic       dev_out_accept;
  logic [7:0] pa_in, pa_out, pb_in, pb_out, pc_in, pc_out;
  logic       pa_oe, pb_oe;
  logic [1:0] pc_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_cmd, m_inbuf, m_outbuf, m_pa, m_pb;
  logic [3:0] m_pcl, m_pch;
  logic       m_rdy, m_full, m_ovr;

  always #5 clk = ~clk;

  polled_port_bridge u_polled_port_bridge (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_in_valid(dev_in_valid),
    .dev_in_data(dev_in_data), .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_accept(dev_out_accept), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
    .pc_oe(pc_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return m_inbuf;
      3'd1: return {5'b0, m_ovr, m_full, m_rdy};
      3'd4: return m_cmd[0] ? pa_in : m_pa;
      3'd5: return m_cmd[1] ? pb_in : m_pb;
      3'd6: return {m_cmd[3] ? pc_in[7:4] : m_pch, m_cmd[2] ? pc_in[3:0] : m_pcl};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic rd, input logic [2:0] a);
    if (!rd) return "R1 idle";
    case (a)
      3'd0: return "R6 data read";
      3'd1: return "R3/R4/R5/R7 status read";
      3'd2: return "R2 command read";
      3'd4, 3'd5, 3'd6: return "R9 port read";
      default: return "R1 unmapped read";
    endcase
  endfunction

  task automatic check_pins();
    chk("R5 out valid", {7'b0, dev_out_valid}, {7'b0, m_full});
    chk("R6 out data", dev_out_data, m_outbuf);
    chk("R8 oe", {4'b0, pc_oe, pb_oe, pa_oe}, {4'b0, ~m_cmd[3:0]});
    chk("R8 pa_out", pa_out, m_cmd[0] ? 8'h00 : m_pa);
    chk("R8 pb_out", pb_out, m_cmd[1] ? 8'h00 : m_pb);
    chk("R8 pc_out", pc_out, {m_cmd[3] ? 4'h0 : m_pch, m_cmd[2] ? 4'h0 : m_pcl});
  endtask

  // One cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(input logic rd, input logic wr, input logic [2:0] a,
                      input logic [7:0] wd, input logic iv, input logic [7:0] id,
                      input logic acc, input string tag);
    logic [7:0] exp_rd;
    logic drd, dwr, srd, nrdy, novr, nfull;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    dev_in_valid = iv; dev_in_data = id; dev_out_accept = acc;
    pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
    exp_rd = rd ? ref_read(a) : 8'h00;
    drd = rd && a == 3'd0; srd = rd && a == 3'd1; dwr = wr && a == 3'd0;
    nrdy  = iv || (m_rdy && !drd);
    novr  = (iv && m_rdy && !drd) || (m_ovr && !srd);
    nfull = dwr || (m_full && !acc);
    m_rdy = nrdy; m_ovr = novr; m_full = nfull;
    if (iv) m_inbuf = id;
    if (dwr) m_outbuf = wd;
    if (wr && a == 3'd2) m_cmd = wd;
    if (wr && a == 3'd4) m_pa = wd;
    if (wr && a == 3'd5) m_pb = wd;
    if (wr && a == 3'd6) begin m_pcl = wd[3:0]; m_pch = wd[7:4]; end
    @(negedge clk);
    chk(tag == "" ? rd_tag(rd, a) : tag, bus_rdata, exp_rd);
    check_pins();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    dev_in_valid = 0; dev_in_data = 0; dev_out_accept = 0;
    pa_in = 0; pb_in = 0; pc_in = 0;
    m_cmd = 8'h0F; m_inbuf = 0; m_outbuf = 0; m_pa = 0; m_pb = 0;
    m_pcl = 0; m_pch = 0; m_rdy = 0; m_full = 0; m_ovr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 rdata after reset", bus_rdata, 8'h00);
    check_pins();
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R10 status after reset");
    // R2 command hidden
    step(0, 1, 3'd2, 8'hA5, 0, 8'h00, 0, "");
    step(1, 0, 3'd2, 8'h00, 0, 8'h00, 0, "R2 command reads zero");
    // R3 status write ignored
    step(0, 1, 3'd1, 8'hFF, 0, 8'h00, 0, "");
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R3 status after write");
    // R4 input ready, R7 overrun
    step(0, 0, 3'd0, 8'h00, 1, 8'h3C, 0, "");
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R4 ready set");
    step(0, 0, 3'd0, 8'h00, 1, 8'h77, 0, "");
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R7 overrun set");
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R7 overrun cleared by status read");
    step(1, 0, 3'd0, 8'h00, 1, 8'h12, 0, "R4 read with arrival");
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R4 ready kept, no overrun R7");
    step(1, 0, 3'd0, 8'h00, 0, 8'h00, 0, "R6 data read");
    // R5 write racing accept
    step(0, 1, 3'd0, 8'hC3, 0, 8'h00, 0, "");
    step(0, 1, 3'd0, 8'h5A, 0, 8'h00, 1, "");
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R5 full kept on write+accept");
    step(0, 0, 3'd0, 8'h00, 0, 8'h00, 1, "");
    step(1, 0, 3'd1, 8'h00, 0, 8'h00, 0, "R5 full cleared");
    // R8/R9 directions
    step(0, 1, 3'd6, 8'h9E, 0, 8'h00, 0, "");
    step(0, 1, 3'd2, 8'h06, 0, 8'h00, 0, "");
    step(1, 0, 3'd6, 8'h00, 0, 8'h00, 0, "R9 port C mixed");
    step(1, 0, 3'd5, 8'h00, 0, 8'h00, 0, "R9 port B input");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [2:0] a;
      op = int'($urandom % 4);
      a = 3'($urandom);
      step(op == 1 || op == 3, op == 2, a, 8'($urandom),
           ($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0, "");
    end
    summary();
  end
endmodule